// File: doc/BRIEF.md
# Calendar Second Counter

This block keeps time of day and calendar date for a real-time clock. A timer source presents elapsed microseconds on `tick_us` with a `tick_valid` strobe. The block adds them into an accumulator, and each time the total goes past one second's worth it moves the calendar forward by one second. The rollover runs from seconds through minutes, hours, weekday, day of month, month and year, and into a century byte.

Every field is held either as packed two-digit BCD or as plain binary, as `bcd_mode` selects. The hour is shown either as 0 to 23 or in 12-hour form with a PM flag. All fields that change at one second boundary are written in the same clock edge, so a reader never sees half of a rollover.

A host reaches the eight calendar bytes through a small side port: a synchronous write and a combinational read, both selected by a 3-bit field index. Leap years, daylight saving and an update-inhibit control are not handled.

Top module: `rtc_calendar_tick`

## Requirements
- R1: On a clock edge with `tick_valid`, the sum S of the accumulator and `tick_us` is formed. If S is strictly greater than US_PER_SEC, one second is counted and the accumulator becomes S minus US_PER_SEC. Otherwise the accumulator becomes S and no field changes. `sec_tick` is high for exactly the cycle in which the advanced values are first visible. `tick_us` never exceeds US_PER_SEC.
- R2: With `bcd_mode`=1 each field increments one decimal digit per nibble, with the units digit in bits 3:0 and a carry into the tens digit in bits 7:4. With `bcd_mode`=0 each field is a plain binary byte.
- R3: A second that counts to 60 (0x60 in BCD) becomes 0 and carries into minutes. Minutes wrap at 60 the same way and carry into hours. If seconds do not wrap, minutes are unchanged.
- R4: With `hour24_mode`=0, hour bit 7 flags PM. Bits 6:0 hold 0 to 11. An hour that reaches 12 or more after the increment is stored as that hour minus 12, with bit 7 set. With `hour24_mode`=1 the hour byte holds 0 to 23 directly.
- R5: When the 24-hour value reaches 24, the hour becomes 0 (AM in 12-hour form) and a new day begins.
- R6: On a new day the weekday becomes (weekday + 1) mod 7.
- R7: On a new day, a day of month equal to the month length becomes 1 and the month increments. Any other day of month simply increments. The month length is 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, 28 for month 2, and 30 for any other month value.
- R8: A month that reaches 13 becomes 1 and the year increments. The year wraps to 0, and the century increments, when it reaches 100 in binary or carries out of 99 in BCD.
- R9: Field selects on `wr_sel` and `rd_sel` are 0 seconds, 1 minutes, 2 hour, 3 weekday, 4 day of month, 5 month, 6 year and 7 century. A write takes effect on the next edge. In the same edge it overrides any advance of that one field, while the other fields still advance from the old values. No field changes without a write or a counted second.
- R10: After reset the accumulator is 0 and the fields read, from century down to seconds: 0x20, 0x00, 0x01, 0x01, 0x00, 0x00, 0x00, 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_valid | input | 1 | Elapsed time is presented this cycle |
| tick_us | input | US_W | Elapsed microseconds |
| bcd_mode | input | 1 | 1 = packed BCD fields, 0 = binary |
| hour24_mode | input | 1 | 1 = 24-hour hour byte, 0 = 12-hour with PM in bit 7 |
| wr_en | input | 1 | Host field write |
| wr_sel | input | 3 | Field written |
| wr_data | input | 8 | Write value |
| rd_sel | input | 3 | Field read |
| rd_data | output | 8 | Selected field, combinational |
| sec_tick | output | 1 | One cycle when a second has just been applied |

## Verification
A tick sampled at one rising edge writes every affected field and raises `sec_tick` at that same edge. The results are therefore due one edge after the stimulus. Host writes follow the same one-edge rule, and reads are combinational from the registered fields. The bench drives each stimulus at a falling edge and removes it at the next falling edge, so exactly one rising edge falls between the two. It then reads all eight fields and `sec_tick` while the clock is low. The expected values come from an integer calendar model in the bench, encoded for the current BCD and hour mode.

// File: rtl/rtc_calendar_tick.sv
module rtc_calendar_tick #(
  parameter int US_PER_SEC = 1000000,
  parameter int US_W       = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_valid,
  input  logic [US_W-1:0] tick_us,
  input  logic            bcd_mode,
  input  logic            hour24_mode,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [7:0]      wr_data,
  input  logic [2:0]      rd_sel,
  output logic [7:0]      rd_data,
  output logic            sec_tick
);
  localparam int ACC_W = $clog2(2 * US_PER_SEC + 1);
  localparam int NF    = 8;
  localparam int F_SEC = 0, F_MIN = 1, F_HR = 2, F_WD = 3;
  localparam int F_DAY = 4, F_MON = 5, F_YR = 6, F_CEN = 7;
  localparam logic [ACC_W-1:0] ONE_SEC = ACC_W'(US_PER_SEC);

  function automatic logic [7:0] inc8(input logic [7:0] v, input logic b);
    logic c, c2;
    logic [3:0] lo, h;
    if (b) begin
      c  = v[3:0] >= 4'd9;
      lo = c ? v[3:0] - 4'd9 : v[3:0] + 4'd1;
      h  = v[7:4] + {3'd0, c};
      c2 = h >= 4'd10;
      return {c2 ? h - 4'd10 : h, lo};
    end
    return v + 8'd1;
  endfunction

  function automatic logic bcd_cout(input logic [7:0] v);
    logic [3:0] h;
    h = v[7:4] + {3'd0, v[3:0] >= 4'd9};
    return h >= 4'd10;
  endfunction

  function automatic logic [7:0] add12(input logic [7:0] v, input logic b);
    logic c;
    if (b) begin
      c = v[3:0] >= 4'd8;
      return {v[7:4] + 4'd1 + {3'd0, c}, c ? v[3:0] - 4'd8 : v[3:0] + 4'd2};
    end
    return v + 8'd12;
  endfunction

  function automatic logic [7:0] sub12(input logic [7:0] v, input logic b);
    logic br;
    if (b) begin
      br = v[3:0] < 4'd2;
      return {v[7:4] - 4'd1 - {3'd0, br}, br ? v[3:0] + 4'd8 : v[3:0] - 4'd2};
    end
    return v - 8'd12;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic b);
    if (b) begin
      case (m)
        8'h01, 8'h03, 8'h05, 8'h07, 8'h08, 8'h10, 8'h12: return 8'h31;
        8'h02:                                           return 8'h28;
        default:                                         return 8'h30;
      endcase
    end
    case (m)
      8'd1, 8'd3, 8'd5, 8'd7, 8'd8, 8'd10, 8'd12: return 8'd31;
      8'd2:                                       return 8'd28;
      default:                                    return 8'd30;
    endcase
  endfunction

  logic [7:0]       cal_q [NF];
  logic [7:0]       cal_d [NF];
  logic [NF-1:0]    upd;
  logic [ACC_W-1:0] acc_q, acc_sum;
  logic             over, adv;
  logic             sec_wrap, min_wrap, day_wrap, last_day, mon_wrap, yr_wrap;
  logic [7:0]       s_inc, m_inc, h_full, h_inc, h_new, mo_inc, y_inc, wd_inc;

  assign acc_sum = acc_q + ACC_W'(tick_us);
  assign over    = acc_sum > ONE_SEC;
  assign adv     = tick_valid && over;
  assign rd_data = cal_q[rd_sel];

  always_comb begin
    s_inc    = inc8(cal_q[F_SEC], bcd_mode);
    sec_wrap = s_inc == (bcd_mode ? 8'h60 : 8'd60);
    m_inc    = inc8(cal_q[F_MIN], bcd_mode);
    min_wrap = m_inc == (bcd_mode ? 8'h60 : 8'd60);
    h_full   = (!hour24_mode && cal_q[F_HR][7]) ?
               add12({1'b0, cal_q[F_HR][6:0]}, bcd_mode) : cal_q[F_HR];
    h_inc    = inc8(h_full, bcd_mode);
    day_wrap = h_inc == (bcd_mode ? 8'h24 : 8'd24);
    h_new    = day_wrap ? 8'd0 : h_inc;
    wd_inc   = inc8(cal_q[F_WD], bcd_mode);
    last_day = cal_q[F_DAY] == month_len(cal_q[F_MON], bcd_mode);
    mo_inc   = inc8(cal_q[F_MON], bcd_mode);
    mon_wrap = mo_inc == (bcd_mode ? 8'h13 : 8'd13);
    y_inc    = inc8(cal_q[F_YR], bcd_mode);
    yr_wrap  = bcd_mode ? bcd_cout(cal_q[F_YR]) : (y_inc == 8'd100);

    cal_d[F_SEC] = sec_wrap ? 8'd0 : s_inc;
    cal_d[F_MIN] = min_wrap ? 8'd0 : m_inc;
    if (hour24_mode || h_new < (bcd_mode ? 8'h12 : 8'd12)) cal_d[F_HR] = h_new;
    else cal_d[F_HR] = sub12(h_new, bcd_mode) | 8'h80;
    cal_d[F_WD]  = wd_inc % 8'd7;
    cal_d[F_DAY] = last_day ? 8'd1 : inc8(cal_q[F_DAY], bcd_mode);
    cal_d[F_MON] = mon_wrap ? 8'd1 : mo_inc;
    cal_d[F_YR]  = yr_wrap ? 8'd0 : y_inc;
    cal_d[F_CEN] = inc8(cal_q[F_CEN], bcd_mode);

    upd[F_SEC] = adv;
    upd[F_MIN] = adv && sec_wrap;
    upd[F_HR]  = upd[F_MIN] && min_wrap;
    upd[F_WD]  = upd[F_HR] && day_wrap;
    upd[F_DAY] = upd[F_WD];
    upd[F_MON] = upd[F_DAY] && last_day;
    upd[F_YR]  = upd[F_MON] && mon_wrap;
    upd[F_CEN] = upd[F_YR] && yr_wrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= adv;
      if (tick_valid) acc_q <= over ? acc_sum - ONE_SEC : acc_sum;
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    localparam logic [7:0] RST_V = (i == F_CEN) ? 8'h20 :
                                   (i == F_DAY || i == F_MON) ? 8'h01 : 8'h00;
    always_ff @(posedge clk) begin
      if (!rst_n) cal_q[i] <= RST_V;
      else if (wr_en && wr_sel == 3'(i)) cal_q[i] <= wr_data;
      else if (upd[i]) cal_q[i] <= cal_d[i];
    end
  end

  p_acc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_us <= US_W'(US_PER_SEC)) |=> (acc_q <= ONE_SEC));

  p_tick_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(tick_valid));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && $past(bcd_mode) && $past(cal_q[F_SEC]) == 8'h59 && !$past(wr_en))
      |-> cal_q[F_SEC] == 8'h00);

  p_min_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && $past(cal_q[F_SEC]) == 8'h10 && !$past(wr_en)) |-> $stable(cal_q[F_MIN]));

  p_wday_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && $past(cal_q[F_WD]) < 8'd7 && !$past(wr_en)) |-> cal_q[F_WD] < 8'd7);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_valid && !wr_en) |=> ($stable(cal_q[F_SEC]) && $stable(cal_q[F_HR]) &&
                                 $stable(cal_q[F_DAY]) && $stable(cal_q[F_CEN]) && !sec_tick));
endmodule

// File: tb/rtc_calendar_tick_bench.sv
`timescale 1ns/1ps
module rtc_calendar_tick_bench;
  localparam int USPS = 1000000;
  logic clk = 0, rst_n = 0, tick_valid = 0, bcd_mode = 0, hour24_mode = 1, wr_en = 0;
  logic [20:0] tick_us = '0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic sec_tick;
  int total = 0, bad = 0;
  bit done = 0;
  int acc = 0;
  int ms, mm, mh, mwd, md, mmo, my, mc;

  rtc_calendar_tick u_rtc_calendar_tick (.clk, .rst_n, .tick_valid, .tick_us, .bcd_mode,
    .hour24_mode, .wr_en, .wr_sel, .wr_data, .rd_sel, .rd_data, .sec_tick);

  always #2.5 clk = ~clk;

  function automatic logic [7:0] enc(int v);
    return bcd_mode ? 8'(((v / 10) << 4) | (v % 10)) : 8'(v);
  endfunction

  function automatic logic [7:0] enc_hr(int h);
    if (hour24_mode || h < 12) return enc(h);
    return enc(h - 12) | 8'h80;
  endfunction

  function automatic logic [63:0] model_vec();
    return {enc(mc), enc(my), enc(mmo), enc(md), enc(mwd), enc_hr(mh), enc(mm), enc(ms)};
  endfunction

  function automatic int mlen(int m);
    if (m == 2) return 28;
    if (m == 1 || m == 3 || m == 5 || m == 7 || m == 8 || m == 10 || m == 12) return 31;
    return 30;
  endfunction

  task automatic model_step();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mwd = (mwd + 1) % 7;
          if (md == mlen(mmo)) begin
            md = 1; mmo++;
            if (mmo == 13) begin
              mmo = 1; my++;
              if (my == 100) begin my = 0; mc++; end
            end
          end else md++;
        end
      end
    end
  endtask

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic read_all(output logic [63:0] v);
    for (int i = 0; i < 8; i++) begin
      rd_sel = 3'(i);
      #0.2;
      v[i*8 +: 8] = rd_data;
    end
  endtask

  task automatic check_fields(string req);
    logic [63:0] v;
    read_all(v);
    check(v == model_vec(), req, v, model_vec());
  endtask

  task automatic write_field(int sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load_model();
    logic [63:0] v;
    v = model_vec();
    for (int i = 0; i < 8; i++) write_field(i, v[i*8 +: 8]);
  endtask

  task automatic tick(int us, string req);
    bit exp_adv;
    @(negedge clk);
    tick_valid = 1; tick_us = 21'(us);
    acc += us;
    exp_adv = acc > USPS;
    if (exp_adv) begin acc -= USPS; model_step(); end
    @(negedge clk);
    tick_valid = 0;
    check(sec_tick == exp_adv, req, 64'(sec_tick), 64'(exp_adv));
  endtask

  task automatic set_model(int s, int m, int h, int wd, int d, int mo, int y, int c);
    ms = s; mm = m; mh = h; mwd = wd; md = d; mmo = mo; my = y; mc = c;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    bcd_mode = 1; hour24_mode = 1;
    set_model(0, 0, 0, 0, 1, 1, 0, 20);
    check_fields("R10 reset fields");
    check(sec_tick == 0, "R10 sec_tick reset", 64'(sec_tick), 64'd0);

    tick(USPS, "R1 exactly one second does not count");
    check_fields("R1 no advance at equality");
    tick(1, "R1 exceed counts");
    check_fields("R1 advanced one second");
    tick(500000, "R9 partial no tick");
    check_fields("R9 fields hold");
    repeat (4) @(negedge clk);
    check(sec_tick == 0, "R1 sec_tick single cycle", 64'(sec_tick), 64'd0);
    check_fields("R9 idle hold");
    tick(499999, "R1 sum equals one second");
    tick(1, "R1 carry of remainder");
    check_fields("R1 remainder second");

    for (int b = 0; b < 2; b++) begin
      bcd_mode = b[0]; hour24_mode = 1;
      for (int s = 0; s < 60; s++) begin
        set_model(s, 7, 3, 2, 10, 4, 8, 20);
        load_model();
        tick(USPS, "R2 second tick");
        check_fields("R3 R2 seconds sweep");
      end
      for (int hm = 0; hm < 2; hm++) begin
        hour24_mode = hm[0];
        for (int h = 0; h < 24; h++) begin
          set_model(59, 59, h, 3, 15, 6, 8, 20);
          load_model();
          tick(USPS, "R4 hour tick");
          check_fields(hm ? "R5 24-hour sweep" : "R4 12-hour sweep");
        end
      end
      hour24_mode = 1;
      for (int wd = 0; wd < 7; wd++) begin
        set_model(59, 59, 23, wd, 5, 3, 8, 20);
        load_model();
        tick(USPS, "R6 day tick");
        check_fields("R6 weekday");
      end
      for (int mo = 0; mo < 14; mo++) begin
        for (int k = 0; k < 2; k++) begin
          set_model(59, 59, 23, 1, mlen(mo) - 1 + k, mo, 50, 20);
          load_model();
          tick(USPS, "R7 day tick");
          check_fields("R7 month length");
        end
      end
      for (int y = 98; y < 100; y++) begin
        set_model(59, 59, 23, 4, 31, 12, y, 20);
        load_model();
        tick(USPS, "R8 year tick");
        check_fields("R8 year and century");
      end
    end

    bcd_mode = 1; hour24_mode = 1;
    set_model(59, 5, 10, 2, 9, 9, 9, 20);
    load_model();
    @(negedge clk);
    wr_en = 1; wr_sel = 3'd0; wr_data = 8'h30;
    tick_valid = 1; tick_us = 21'(USPS);
    acc += USPS;
    if (acc > USPS) begin acc -= USPS; model_step(); end
    ms = 30;
    @(negedge clk);
    wr_en = 0; tick_valid = 0;
    check_fields("R9 write overrides advance of one field");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule